// File: doc/BRIEF.md
# Debug Register Access Chain

This block is a data-register chain that sits behind a test access port. It lets a debugger read and write a bank of 32-bit debug registers: breakpoint value and control, watchpoint value and control, and a vector-catch word. The TAP controller lives outside the block. It supplies one-cycle strobes for the capture, shift and update phases and a serial input bit, and it receives the serial output bit. Each scan is 40 bits long. The first bit in and out is a single flag. Thirty-two data bits follow, least significant bit first, and then seven address bits, least significant bit first.

Accesses are pipelined by one scan. An update launches the access that was just shifted in, and the access takes a fixed number of clock cycles. The next capture loads the address and data of that finished access, together with a ready flag, so the result comes out on the following scan. A read therefore delivers its data one scan later, and the host appends a harmless dummy scan (write, address 0, data 0) to collect the last result. The breakpoint and watchpoint enable outputs and the vector-catch word are driven directly from the register bank to the comparators around the block.

Top module: `dbg_reg_chain`

## Requirements
- R1: After reset every register is zero and every enable output is low. The first capture returns flag 1, data 0 and address 0.
- R2: The chain is 40 bits long. After a capture, tdo shows the flag, then data bits 0..31, then address bits 0..6, one per shift. A bit shifted into tdi appears on tdo 40 shifts later.
- R3: A write scan (flag bit 1) is echoed on the next scan: the captured address and data equal the values that were written, including at addresses that ignore the write.
- R4: A read scan (flag bit 0) returns, on the next scan, its address and the register's content at the moment the access was carried out.
- R5: An access completes 2 clock cycles after the update edge that launched it. A capture at the first or second edge after that update returns flag 0. A capture from the third edge on returns flag 1.
- R6: An update that arrives while an access is still in progress is dropped. It neither changes a register nor replaces the pending result.
- R7: Address map. Address 7 is vector catch. Addresses 64+i, 80+i, 96+i and 112+i are, in that order, breakpoint value, breakpoint control, watchpoint value and watchpoint control for index i (0..15).
- R8: Reads of unimplemented addresses (1..6 and 8..63) return zero. Writes to them change nothing.
- R9: Address 0 ignores writes and reads as zero, so a dummy write of 0 to address 0 has no effect.
- R10: bpEnable[i] (wpEnable[i]) is high exactly when breakpoint (watchpoint) control register i is nonzero, so writing zero disables the unit. vectorCatch always equals the vector-catch register. These outputs change only when an access completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| captureDr | input | 1 | Capture phase strobe |
| shiftDr | input | 1 | Shift phase strobe, one bit per cycle |
| updateDr | input | 1 | Update phase strobe, launches an access |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, bit 0 of the chain |
| bpEnable | output | NUM_BP | Breakpoint unit enables |
| wpEnable | output | NUM_WP | Watchpoint unit enables |
| vectorCatch | output | 32 | Vector-catch register content |

## Verification
The bench targets the one-scan offset. A design that returned read data on the same scan, or that failed to echo writes, would put the wrong address and data at the front of the next scan. It also captures one, two and three cycles after an update: ready asserted one cycle early, or held one cycle late, shows up as a wrong first bit. An update issued while busy is checked to leave the vector-catch word and the pending result untouched. Writes to address 0 and to a hole in the map are read back, to catch decoding that aliases onto real registers. Clearing a breakpoint control word to zero must drop its enable output.

// File: rtl/dbg_chain_pkg.sv
package dbg_chain_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 7;
  localparam int CHAIN_W  = 1 + DATA_W + ADDR_W;
  localparam int VCR_ADDR = 7;
  localparam int BVR_BASE = 64;
  localparam int BCR_BASE = 80;
  localparam int WVR_BASE = 96;
  localparam int WCR_BASE = 112;
  localparam int BANK_SPAN = 16;

  typedef struct packed {
    logic capture;
    logic shift;
    logic launch;
    logic commit;
  } chainStrb_t;
endpackage

// File: rtl/dbg_chain_ctrl.sv
module dbg_chain_ctrl
  import dbg_chain_pkg::*;
#(
  parameter int ACCESS_LAT = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       captureDr,
  input  logic       shiftDr,
  input  logic       updateDr,
  output chainStrb_t strb,
  output logic       busy
);
  localparam int CNT_W = $clog2(ACCESS_LAT + 1);

  logic [CNT_W-1:0] latCnt;

  assign busy         = (latCnt != '0);
  assign strb.capture = captureDr;
  assign strb.shift   = shiftDr && !captureDr;
  assign strb.launch  = updateDr && !captureDr && !shiftDr && !busy;
  assign strb.commit  = (latCnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latCnt <= '0;
    end else if (strb.launch) begin
      latCnt <= CNT_W'(ACCESS_LAT);
    end else if (busy) begin
      latCnt <= latCnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/dbg_chain_datapath.sv
module dbg_chain_datapath
  import dbg_chain_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  chainStrb_t        strb,
  input  logic              busy,
  input  logic              tdi,
  input  logic [DATA_W-1:0] rdData,
  output logic              tdo,
  output logic [ADDR_W-1:0] acsAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              wrEn
);
  logic [CHAIN_W-1:0] shiftReg;
  logic               reqWr;
  logic [DATA_W-1:0]  reqData;
  logic [ADDR_W-1:0]  reqAddr;
  logic [DATA_W-1:0]  resData;
  logic [ADDR_W-1:0]  resAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strb.capture) begin
      shiftReg <= {resAddr, resData, !busy};
    end else if (strb.shift) begin
      shiftReg <= {tdi, shiftReg[CHAIN_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqWr   <= 1'b0;
      reqData <= '0;
      reqAddr <= '0;
    end else if (strb.launch) begin
      reqWr   <= shiftReg[0];
      reqData <= shiftReg[DATA_W:1];
      reqAddr <= shiftReg[CHAIN_W-1:DATA_W+1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resData <= '0;
      resAddr <= '0;
    end else if (strb.commit) begin
      resAddr <= reqAddr;
      resData <= reqWr ? reqData : rdData;
    end
  end

  assign tdo     = shiftReg[0];
  assign acsAddr = reqAddr;
  assign wrData  = reqData;
  assign wrEn    = strb.commit && reqWr;
endmodule

// File: rtl/dbg_reg_file.sv
module dbg_reg_file
  import dbg_chain_pkg::*;
#(
  parameter int NUM_BP = 16,
  parameter int NUM_WP = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_BP-1:0] bpEnable,
  output logic [NUM_WP-1:0] wpEnable,
  output logic [DATA_W-1:0] vectorCatch
);
  localparam int IDX_W = $clog2(BANK_SPAN);

  logic [NUM_BP*DATA_W-1:0] bvrFlat, bcrFlat;
  logic [NUM_WP*DATA_W-1:0] wvrFlat, wcrFlat;
  logic [DATA_W-1:0]        vcrReg;

  for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
    logic [DATA_W-1:0] valReg, ctlReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        valReg <= '0;
        ctlReg <= '0;
      end else if (wrEn) begin
        if (addr == ADDR_W'(BVR_BASE + i)) valReg <= wrData;
        if (addr == ADDR_W'(BCR_BASE + i)) ctlReg <= wrData;
      end
    end
    assign bvrFlat[i*DATA_W +: DATA_W] = valReg;
    assign bcrFlat[i*DATA_W +: DATA_W] = ctlReg;
    assign bpEnable[i] = |ctlReg;
  end

  for (genvar i = 0; i < NUM_WP; i++) begin : g_wp
    logic [DATA_W-1:0] valReg, ctlReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        valReg <= '0;
        ctlReg <= '0;
      end else if (wrEn) begin
        if (addr == ADDR_W'(WVR_BASE + i)) valReg <= wrData;
        if (addr == ADDR_W'(WCR_BASE + i)) ctlReg <= wrData;
      end
    end
    assign wvrFlat[i*DATA_W +: DATA_W] = valReg;
    assign wcrFlat[i*DATA_W +: DATA_W] = ctlReg;
    assign wpEnable[i] = |ctlReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vcrReg <= '0;
    end else if (wrEn && addr == ADDR_W'(VCR_ADDR)) begin
      vcrReg <= wrData;
    end
  end

  assign vectorCatch = vcrReg;

  logic [IDX_W-1:0]        idx;
  logic [ADDR_W-IDX_W-1:0] bank;
  int                      idxI;

  assign idx  = addr[IDX_W-1:0];
  assign bank = addr[ADDR_W-1:IDX_W];
  assign idxI = int'(idx);

  always_comb begin
    rdData = '0;
    if (bank == (ADDR_W-IDX_W)'(BVR_BASE / BANK_SPAN)) begin
      if (idxI < NUM_BP) rdData = bvrFlat[idxI*DATA_W +: DATA_W];
    end else if (bank == (ADDR_W-IDX_W)'(BCR_BASE / BANK_SPAN)) begin
      if (idxI < NUM_BP) rdData = bcrFlat[idxI*DATA_W +: DATA_W];
    end else if (bank == (ADDR_W-IDX_W)'(WVR_BASE / BANK_SPAN)) begin
      if (idxI < NUM_WP) rdData = wvrFlat[idxI*DATA_W +: DATA_W];
    end else if (bank == (ADDR_W-IDX_W)'(WCR_BASE / BANK_SPAN)) begin
      if (idxI < NUM_WP) rdData = wcrFlat[idxI*DATA_W +: DATA_W];
    end else if (addr == ADDR_W'(VCR_ADDR)) begin
      rdData = vcrReg;
    end
  end
endmodule

// File: rtl/dbg_reg_chain.sv
module dbg_reg_chain
  import dbg_chain_pkg::*;
#(
  parameter int NUM_BP     = 16,
  parameter int NUM_WP     = 16,
  parameter int ACCESS_LAT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              captureDr,
  input  logic              shiftDr,
  input  logic              updateDr,
  input  logic              tdi,
  output logic              tdo,
  output logic [NUM_BP-1:0] bpEnable,
  output logic [NUM_WP-1:0] wpEnable,
  output logic [DATA_W-1:0] vectorCatch
);
  chainStrb_t        strb;
  logic              busy;
  logic              wrEn;
  logic [ADDR_W-1:0] acsAddr;
  logic [DATA_W-1:0] wrData;
  logic [DATA_W-1:0] rdData;

  dbg_chain_ctrl #(.ACCESS_LAT(ACCESS_LAT)) u_ctrl (
    .clk(clk), .rstN(rstN), .captureDr(captureDr), .shiftDr(shiftDr),
    .updateDr(updateDr), .strb(strb), .busy(busy)
  );

  dbg_chain_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy), .tdi(tdi),
    .rdData(rdData), .tdo(tdo), .acsAddr(acsAddr), .wrData(wrData), .wrEn(wrEn)
  );

  dbg_reg_file #(.NUM_BP(NUM_BP), .NUM_WP(NUM_WP)) u_rf (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(acsAddr), .wrData(wrData),
    .rdData(rdData), .bpEnable(bpEnable), .wpEnable(wpEnable),
    .vectorCatch(vectorCatch)
  );
endmodule

// File: rtl/dbg_reg_chain_chk.sv
module dbg_reg_chain_chk #(
  parameter int NUM_BP = 16,
  parameter int NUM_WP = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              captureDr,
  input logic              updateDr,
  input logic              tdo,
  input logic              busy,
  input logic              commit,
  input logic [NUM_BP-1:0] bpEnable,
  input logic [NUM_WP-1:0] wpEnable,
  input logic [31:0]       vectorCatch
);
  // R5
  ready_low_after_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    captureDr && $past(updateDr) |=> !tdo);

  // R5
  ready_low_while_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    captureDr && busy |=> !tdo);

  // R6
  busy_starts_on_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(updateDr));

  // R10
  bp_enable_on_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(bpEnable) |-> $past(commit));

  // R10
  wp_enable_on_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(wpEnable) |-> $past(commit));

  // R10
  vcatch_on_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(vectorCatch) |-> $past(commit));
endmodule

bind dbg_reg_chain dbg_reg_chain_chk #(.NUM_BP(NUM_BP), .NUM_WP(NUM_WP)) u_chk (
  .clk(clk), .rstN(rstN), .captureDr(captureDr), .updateDr(updateDr), .tdo(tdo),
  .busy(busy), .commit(strb.commit), .bpEnable(bpEnable), .wpEnable(wpEnable),
  .vectorCatch(vectorCatch)
);

// File: tb/tb_dbg_reg_chain.sv
`timescale 1ns/1ps
module tb_dbg_reg_chain;
  localparam int NBP = 16;
  localparam int NWP = 16;
  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic captureDr = 1'b0, shiftDr = 1'b0, updateDr = 1'b0, tdi = 1'b0;
  logic tdo;
  logic [NBP-1:0] bpEnable;
  logic [NWP-1:0] wpEnable;
  logic [31:0] vectorCatch;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dbg_reg_chain #(.NUM_BP(NBP), .NUM_WP(NWP), .ACCESS_LAT(LAT)) dut (
    .clk(clk), .rstN(rstN), .captureDr(captureDr), .shiftDr(shiftDr),
    .updateDr(updateDr), .tdi(tdi), .tdo(tdo), .bpEnable(bpEnable),
    .wpEnable(wpEnable), .vectorCatch(vectorCatch)
  );

  // reference model state
  logic [31:0] mem [int];
  bit q[$];
  int pend = 0;
  bit mWr;
  logic [31:0] mData;
  int mAddr;
  logic [31:0] resData = 0;
  int resAddr = 0;

  function automatic bit implemented(int a);
    if (a == 7) return 1;
    if (a >= 64 && a < 80) return (a - 64) < NBP;
    if (a >= 80 && a < 96) return (a - 80) < NBP;
    if (a >= 96 && a < 112) return (a - 96) < NWP;
    if (a >= 112 && a < 128) return (a - 112) < NWP;
    return 0;
  endfunction

  function automatic logic [31:0] rd(int a);
    if (implemented(a) && mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic modelStep(bit c, bit s, bit u, bit b);
    int oldPend = pend;
    if (c) begin
      q.delete();
      q.push_back(oldPend == 0);
      for (int k = 0; k < 32; k++) q.push_back(resData[k]);
      for (int k = 0; k < 7; k++) q.push_back(resAddr[k]);
    end else if (s) begin
      if (q.size() == 40) begin
        void'(q.pop_front());
        q.push_back(b);
      end
    end
    if (oldPend > 0) begin
      pend--;
      if (pend == 0) begin
        if (mWr) begin
          if (implemented(mAddr)) mem[mAddr] = mData;
          resData = mData;
        end else begin
          resData = rd(mAddr);
        end
        resAddr = mAddr;
      end
    end else if (u && !c && !s && q.size() == 40) begin
      mWr = q[0];
      for (int k = 0; k < 32; k++) mData[k] = q[1+k];
      mAddr = 0;
      for (int k = 0; k < 7; k++) mAddr[k] = q[33+k];
      pend = LAT;
    end
  endtask

  task automatic compareOutputs();
    if (q.size() == 40) chk(tdo === q[0], "R2 tdo stream", tdo, q[0]);
    for (int i = 0; i < NBP; i++)
      chk(bpEnable[i] === (rd(80+i) != 0), "R10 bpEnable", bpEnable[i], rd(80+i) != 0);
    for (int i = 0; i < NWP; i++)
      chk(wpEnable[i] === (rd(112+i) != 0), "R10 wpEnable", wpEnable[i], rd(112+i) != 0);
    chk(vectorCatch === rd(7), "R10 vectorCatch", vectorCatch, rd(7));
  endtask

  task automatic tick(bit c, bit s, bit u, bit b);
    captureDr = c; shiftDr = s; updateDr = u; tdi = b;
    @(posedge clk);
    modelStep(c, s, u, b);
    @(negedge clk);
    compareOutputs();
  endtask

  task automatic scan(input bit wr, input logic [31:0] data, input logic [6:0] addr,
                      input int gap, output bit rdy, output logic [31:0] od,
                      output logic [6:0] oa);
    bit inBits[40];
    bit outBits[40];
    inBits[0] = wr;
    for (int k = 0; k < 32; k++) inBits[1+k] = data[k];
    for (int k = 0; k < 7; k++) inBits[33+k] = addr[k];
    tick(1, 0, 0, 0);
    outBits[0] = tdo;
    for (int k = 0; k < 40; k++) begin
      tick(0, 1, 0, inBits[k]);
      if (k < 39) outBits[k+1] = tdo;
    end
    tick(0, 0, 1, 0);
    for (int k = 0; k < gap; k++) tick(0, 0, 0, 0);
    rdy = outBits[0];
    for (int k = 0; k < 32; k++) od[k] = outBits[1+k];
    for (int k = 0; k < 7; k++) oa[k] = outBits[33+k];
  endtask

  task automatic expectScan(string req, bit rdy, logic [31:0] od, logic [6:0] oa,
                            bit eRdy, logic [31:0] eD, logic [6:0] eA);
    chk(rdy == eRdy, {req, " ready"}, rdy, eRdy);
    chk(od == eD, {req, " data"}, od, eD);
    chk(oa == eA, {req, " address"}, oa, eA);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    bit r;
    logic [31:0] d;
    logic [6:0] a;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 enables low during reset
    chk(bpEnable == 0 && wpEnable == 0 && vectorCatch == 0, "R1 reset outputs",
        {bpEnable, wpEnable}, 0);
    rstN = 1'b1;
    @(negedge clk);

    scan(0, 32'h0, 7'd7, 3, r, d, a);
    expectScan("R1", r, d, a, 1, 32'h0, 7'd0);
    scan(1, 32'hDEADBEEF, 7'd67, 3, r, d, a);
    expectScan("R4 read vcr", r, d, a, 1, 32'h0, 7'd7);
    scan(1, 32'h5, 7'd83, 3, r, d, a);
    expectScan("R3 echo bvr3", r, d, a, 1, 32'hDEADBEEF, 7'd67);
    scan(1, 32'h1, 7'd114, 3, r, d, a);
    expectScan("R3 echo bcr3", r, d, a, 1, 32'h5, 7'd83);
    chk(bpEnable[3] === 1'b1, "R10 bp3 enabled", bpEnable[3], 1);
    scan(1, 32'h1F, 7'd7, 3, r, d, a);
    chk(wpEnable[2] === 1'b1, "R10 wp2 enabled", wpEnable[2], 1);
    scan(0, 32'h0, 7'd67, 3, r, d, a);
    chk(vectorCatch === 32'h1F, "R7 vector catch", vectorCatch, 32'h1F);
    scan(0, 32'h0, 7'd114, 3, r, d, a);
    expectScan("R7 R4 read bvr3", r, d, a, 1, 32'hDEADBEEF, 7'd67);
    scan(1, 32'hFFFF, 7'h20, 3, r, d, a);
    expectScan("R7 read wcr2", r, d, a, 1, 32'h1, 7'd114);
    scan(0, 32'h0, 7'h20, 3, r, d, a);
    expectScan("R3 echo hole", r, d, a, 1, 32'hFFFF, 7'h20);
    scan(1, 32'h1234, 7'd0, 3, r, d, a);
    expectScan("R8 hole reads zero", r, d, a, 1, 32'h0, 7'h20);
    scan(0, 32'h0, 7'd0, 3, r, d, a);
    expectScan("R3 echo addr0", r, d, a, 1, 32'h1234, 7'd0);
    scan(1, 32'h0, 7'd83, 0, r, d, a);
    expectScan("R9 addr0 reads zero", r, d, a, 1, 32'h0, 7'd0);
    scan(0, 32'h0, 7'd83, 1, r, d, a);
    chk(r == 1'b0, "R5 capture one cycle after update", r, 0);
    chk(bpEnable[3] === 1'b0, "R10 bp3 disabled by zero", bpEnable[3], 0);
    scan(0, 32'h0, 7'd7, 2, r, d, a);
    chk(r == 1'b0, "R5 capture two cycles after update", r, 0);
    scan(1, 32'hA5, 7'd7, 0, r, d, a);
    chk(r == 1'b1, "R5 capture three cycles after update", r, 1);
    tick(0, 1, 0, 1);
    tick(0, 0, 1, 0);
    repeat (3) tick(0, 0, 0, 0);
    scan(1, 32'h0, 7'd0, 3, r, d, a);
    expectScan("R6 dropped update", r, d, a, 1, 32'hA5, 7'd7);
    chk(vectorCatch === 32'hA5, "R6 vector catch kept", vectorCatch, 32'hA5);
    scan(0, 32'h0, 7'd5, 3, r, d, a);
    expectScan("R9 dummy echo", r, d, a, 1, 32'h0, 7'd0);
    chk(vectorCatch === 32'hA5, "R9 dummy harmless", vectorCatch, 32'hA5);
    scan(1, 32'h0, 7'd0, 3, r, d, a);
    expectScan("R8 hole read", r, d, a, 1, 32'h0, 7'd5);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule